// File: doc/BRIEF.md
# USB Host Controller Power-Up Sequencer

This block is a hardware state machine that takes a USB host controller, its wrapper logic and its PHYs from full reset to a running host-only configuration. A one-cycle start pulse latches the configuration inputs, asserts every reset and then walks a fixed sequence. The sequence picks the controller clock divider from the bus clock frequency and checks that the divider setting took effect. It then programs the reference clock fields and the PLL multiplier and powers the PHYs. Finally it releases the resets one at a time, with a timed wait between releases.

The divider select and the PLL multiplier are worked out in hardware from the clock inputs, so no software has to compute them. Port power control is set up between the wrapper reset release and the host-core reset release. When port power is in use, a separate settle wait is inserted there. The block ends in a done state or an error state, and that state holds until the next start pulse.

Top module: `usb_pwrup_seq`

## Requirements
- R1: After the synchronous reset, the three controller resets are 1, `drd_mode` is 1, and every other control output is 0. This includes `hdiv_rst`, `hclk_en`, all enables and the port-power bits. `done` and `error` are both 0.
- R2: The start pulse is sampled at clock edge 0. At that edge `wrap_rst`, `core_rst` and `phy_rst` are set. At edge 1 `hdiv_rst` is set. `hdiv_rst` is only ever high while all three resets are high.
- R3: Divider codes 0..7 stand for ratios 1, 2, 4, 6, 8, 16, 24, 32. The codes are tried from 7 down to 0. At edge 2, `hdiv_sel` takes the first code whose ratio r meets 150*r <= `bus_mhz` <= 300*r, and `hclk_en` is set. If no code fits, `error` rises at edge 2.
- R4: At edge 3, `div_sel_rb` and `hclk_en_rb` are compared with the written select and with 1. On a mismatch, `error` rises at edge 3 and no reference or PHY setup is done: `ssp_en` stays 0 and `wrap_rst` stays 1. On a match, `hdiv_rst` clears.
- R5: `ref_sel` = {`hs_use_pll`, `ss_src`}. The codes are: 0 = source 0 for both speeds, 1 = source 1 for both, 2 = PLL reference for HS with source 0 for SS, 3 = PLL reference for HS with source 1 for SS.
- R6: `ref_fsel` is 0x27 when the rate is treated as 100 MHz and `ref_sel` is below 2. Otherwise it is 0x07.
- R7: `rate_code` 0 = 100 MHz, 1 = 50 MHz, 2 = 125 MHz, 3 = unsupported (handled as 100 MHz). `mpll_mul` is 0x19, 0x32, 0x28 and 0x19 for these codes.
- R8: `ssc_en`, `ssp_en`, `hs_phy_pwr` and `ss_phy_pwr` rise together at edge 4. This happens after `hdiv_rst` has cleared, with `hclk_en` set.
- R9: N = max(`wait_cycles`, 10) and M = max(`settle_cycles`, 10). `wrap_rst` falls N cycles after `ssp_en` rises. `core_rst` falls N cycles later, or N+M cycles later when port power is present.
- R10: The port-power bits are set N cycles after the `wrap_rst` release. If `port_pwr_present` is 1, `ppc_en` = 1 and `ppc_active_high` = !`port_pwr_active_low`. Otherwise both are 0.
- R11: `sclk_en` rises N cycles after `core_rst` falls. `drd_mode` clears one cycle later. `phy_rst` clears and `done` rises one cycle after that, which is edge 6+3N(+M) counted from start.
- R12: `done` and `error` are never both 1, and each holds until the next start pulse. A start pulse while a sequence is running is ignored and does not change its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins a sequence |
| rate_code | input | 2 | Reference clock rate code |
| hs_use_pll | input | 1 | HS reference comes from the PLL reference |
| ss_src | input | 1 | SS reference source (0 or 1) |
| bus_mhz | input | BUS_W | Bus clock frequency in MHz |
| port_pwr_present | input | 1 | Port power control is in use |
| port_pwr_active_low | input | 1 | Port power switch is active low |
| wait_cycles | input | WAIT_W | Length of the reset-release wait |
| settle_cycles | input | WAIT_W | Length of the port-power settle wait |
| div_sel_rb | input | 3 | Divider select as read back from the controller |
| hclk_en_rb | input | 1 | Clock enable as read back from the controller |
| wrap_rst | output | 1 | Wrapper reset |
| core_rst | output | 1 | Host-core reset |
| phy_rst | output | 1 | PHY reset |
| hdiv_rst | output | 1 | Controller clock divider reset |
| hdiv_sel | output | 3 | Controller clock divider select |
| hclk_en | output | 1 | Controller clock enable |
| ref_sel | output | 2 | Reference clock source select |
| ref_fsel | output | 6 | Reference frequency field |
| mpll_mul | output | 7 | PLL multiplier |
| ssc_en | output | 1 | Spread-spectrum enable |
| ssp_en | output | 1 | SuperSpeed reference enable |
| hs_phy_pwr | output | 1 | HS PHY power enable |
| ss_phy_pwr | output | 1 | SS PHY power enable |
| ppc_en | output | 1 | Port power control enable |
| ppc_active_high | output | 1 | Port power polarity is active high |
| sclk_en | output | 1 | Coprocessor clock enable |
| drd_mode | output | 1 | Dual-role mode (0 forces host mode) |
| done | output | 1 | Sequence completed |
| error | output | 1 | Sequence aborted |

## Verification
The bench runs the sequence with bus clocks that land on the smallest ratio, a middle ratio, the largest ratio and no ratio at all, so a wrong scan direction or an off-by-one bound gives a different select. Each rate code appears with reference selects on both sides of 2, which separates the 0x27/0x07 frequency choice and the multiplier for an unsupported rate. Wait values below and above the minimum, with port power present (both polarities) and absent, show whether the settle wait is inserted only where it belongs and whether each release lands on its exact cycle. A corrupted readback, a start pulse in mid-sequence and a restart from the error state cover the abort and hold behaviour.

// File: rtl/usbpu_pkg.sv
package usbpu_pkg;

    localparam int DIV_SEL_W  = 3;
    localparam int NUM_RATIOS = 1 << DIV_SEL_W;
    localparam int H_MIN_MHZ  = 150;
    localparam int H_MAX_MHZ  = 300;

    typedef enum logic [1:0] {
        RATE_100   = 2'd0,
        RATE_50    = 2'd1,
        RATE_125   = 2'd2,
        RATE_OTHER = 2'd3
    } rate_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ASSERT,
        ST_DIV_PICK,
        ST_DIV_CHK,
        ST_REF_CFG,
        ST_WAIT_WRAP,
        ST_WAIT_PWR,
        ST_SETTLE,
        ST_WAIT_CORE,
        ST_HOST_MODE,
        ST_PHY_REL,
        ST_DONE,
        ST_ERR
    } seq_state_e;

    typedef struct packed {
        logic                 wrap_rst;
        logic                 core_rst;
        logic                 phy_rst;
        logic                 div_rst;
        logic [DIV_SEL_W-1:0] div_sel;
        logic                 hclk_en;
        logic [1:0]           ref_sel;
        logic [5:0]           ref_fsel;
        logic [6:0]           mpll_mul;
        logic                 ssc_en;
        logic                 ssp_en;
        logic                 hs_pwr;
        logic                 ss_pwr;
        logic                 ppc_en;
        logic                 ppc_high;
        logic                 sclk_en;
        logic                 drd_mode;
    } ctl_t;

    typedef struct packed {
        rate_e rate;
        logic  hs_pll;
        logic  ss_src;
        logic  pwr_present;
        logic  pwr_low;
    } cfg_t;

    // Divider code to division ratio.
    function automatic int unsigned ratio_of(int unsigned code);
        case (code)
            0:       return 1;
            1:       return 2;
            2:       return 4;
            3:       return 6;
            4:       return 8;
            5:       return 16;
            6:       return 24;
            default: return 32;
        endcase
    endfunction

    // Control word held while everything sits in reset.
    function automatic ctl_t ctl_reset();
        ctl_t c;
        c          = '0;
        c.wrap_rst = 1'b1;
        c.core_rst = 1'b1;
        c.phy_rst  = 1'b1;
        c.drd_mode = 1'b1;
        return c;
    endfunction

endpackage

// File: rtl/usbpu_div_pick.sv
module usbpu_div_pick
    import usbpu_pkg::*;
#(
    parameter int BUS_W = 14
) (
    input  logic [BUS_W-1:0]     bus_mhz,
    output logic [DIV_SEL_W-1:0] sel,
    output logic                 found
);
    localparam int CW = 32;

    logic [CW-1:0]         bus_ext;
    logic [NUM_RATIOS-1:0] fit;

    assign bus_ext = CW'(bus_mhz);

    // One range comparator per ratio; divided clock in [min, max] inclusive.
    for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_fit
        localparam int unsigned LO = H_MIN_MHZ * ratio_of(g);
        localparam int unsigned HI = H_MAX_MHZ * ratio_of(g);
        assign fit[g] = (bus_ext >= CW'(LO)) && (bus_ext <= CW'(HI));
    end

    // Largest ratio wins.
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
            if (!found && fit[i]) begin
                found = 1'b1;
                sel   = DIV_SEL_W'(i);
            end
        end
    end

endmodule

// File: rtl/usbpu_ref_cfg.sv
module usbpu_ref_cfg
    import usbpu_pkg::*;
(
    input  rate_e      rate,
    input  logic       hs_pll,
    input  logic       ss_src,
    output logic [1:0] ref_sel,
    output logic [5:0] ref_fsel,
    output logic [6:0] mpll_mul
);
    logic as_100;

    assign ref_sel = {hs_pll, ss_src};
    assign as_100  = (rate == RATE_100) || (rate == RATE_OTHER);

    always_comb begin
        unique case (rate)
            RATE_50:  mpll_mul = 7'h32;
            RATE_125: mpll_mul = 7'h28;
            default:  mpll_mul = 7'h19;
        endcase
        ref_fsel = (as_100 && !ref_sel[1]) ? 6'h27 : 6'h07;
    end

endmodule

// File: rtl/usbpu_wait_timer.sv
module usbpu_wait_timer #(
    parameter int WAIT_W   = 16,
    parameter int MIN_WAIT = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WAIT_W-1:0] len,
    output logic              expired
);
    localparam logic [WAIT_W-1:0] MIN_V = WAIT_W'(MIN_WAIT);

    logic [WAIT_W-1:0] cnt;
    logic [WAIT_W-1:0] eff;

    assign eff     = (len < MIN_V) ? MIN_V : len;
    assign expired = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= eff - 1'b1;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/usb_pwrup_seq.sv
module usb_pwrup_seq
    import usbpu_pkg::*;
#(
    parameter int BUS_W    = 14,
    parameter int WAIT_W   = 16,
    parameter int MIN_WAIT = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        rate_code,
    input  logic              hs_use_pll,
    input  logic              ss_src,
    input  logic [BUS_W-1:0]  bus_mhz,
    input  logic              port_pwr_present,
    input  logic              port_pwr_active_low,
    input  logic [WAIT_W-1:0] wait_cycles,
    input  logic [WAIT_W-1:0] settle_cycles,
    input  logic [2:0]        div_sel_rb,
    input  logic              hclk_en_rb,
    output logic              wrap_rst,
    output logic              core_rst,
    output logic              phy_rst,
    output logic              hdiv_rst,
    output logic [2:0]        hdiv_sel,
    output logic              hclk_en,
    output logic [1:0]        ref_sel,
    output logic [5:0]        ref_fsel,
    output logic [6:0]        mpll_mul,
    output logic              ssc_en,
    output logic              ssp_en,
    output logic              hs_phy_pwr,
    output logic              ss_phy_pwr,
    output logic              ppc_en,
    output logic              ppc_active_high,
    output logic              sclk_en,
    output logic              drd_mode,
    output logic              done,
    output logic              error
);
    seq_state_e        state_q;
    ctl_t              ctl_q;
    cfg_t              cfg_q;
    logic [BUS_W-1:0]  bus_q;
    logic [WAIT_W-1:0] wait_q;
    logic [WAIT_W-1:0] settle_q;
    logic              done_q;
    logic              err_q;

    logic [DIV_SEL_W-1:0] pick_sel;
    logic                 pick_found;
    logic [1:0]           rc_sel;
    logic [5:0]           rc_fsel;
    logic [6:0]           rc_mul;
    logic                 tmr_load;
    logic [WAIT_W-1:0]    tmr_len;
    logic                 tmr_exp;

    usbpu_div_pick #(.BUS_W(BUS_W)) u_pick (
        .bus_mhz (bus_q),
        .sel     (pick_sel),
        .found   (pick_found)
    );

    usbpu_ref_cfg u_ref (
        .rate     (cfg_q.rate),
        .hs_pll   (cfg_q.hs_pll),
        .ss_src   (cfg_q.ss_src),
        .ref_sel  (rc_sel),
        .ref_fsel (rc_fsel),
        .mpll_mul (rc_mul)
    );

    usbpu_wait_timer #(.WAIT_W(WAIT_W), .MIN_WAIT(MIN_WAIT)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .len     (tmr_len),
        .expired (tmr_exp)
    );

    // Timer is reloaded on entry to every timed state.
    always_comb begin
        tmr_load = 1'b0;
        tmr_len  = wait_q;
        unique case (state_q)
            ST_REF_CFG:   tmr_load = 1'b1;
            ST_WAIT_WRAP: tmr_load = tmr_exp;
            ST_WAIT_PWR: begin
                tmr_load = tmr_exp;
                if (cfg_q.pwr_present) tmr_len = settle_q;
            end
            ST_SETTLE:    tmr_load = tmr_exp;
            default:      tmr_load = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            ctl_q    <= ctl_reset();
            cfg_q    <= '0;
            bus_q    <= '0;
            wait_q   <= '0;
            settle_q <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DONE, ST_ERR: begin
                    if (start) begin
                        ctl_q             <= ctl_reset();
                        cfg_q.rate        <= rate_e'(rate_code);
                        cfg_q.hs_pll      <= hs_use_pll;
                        cfg_q.ss_src      <= ss_src;
                        cfg_q.pwr_present <= port_pwr_present;
                        cfg_q.pwr_low     <= port_pwr_active_low;
                        bus_q             <= bus_mhz;
                        wait_q            <= wait_cycles;
                        settle_q          <= settle_cycles;
                        done_q            <= 1'b0;
                        err_q             <= 1'b0;
                        state_q           <= ST_ASSERT;
                    end
                end
                ST_ASSERT: begin
                    ctl_q.div_rst <= 1'b1;
                    state_q       <= ST_DIV_PICK;
                end
                ST_DIV_PICK: begin
                    if (pick_found) begin
                        ctl_q.div_sel <= pick_sel;
                        ctl_q.hclk_en <= 1'b1;
                        state_q       <= ST_DIV_CHK;
                    end else begin
                        err_q   <= 1'b1;
                        state_q <= ST_ERR;
                    end
                end
                ST_DIV_CHK: begin
                    if ((div_sel_rb != ctl_q.div_sel) || !hclk_en_rb) begin
                        err_q   <= 1'b1;
                        state_q <= ST_ERR;
                    end else begin
                        ctl_q.div_rst <= 1'b0;
                        state_q       <= ST_REF_CFG;
                    end
                end
                ST_REF_CFG: begin
                    ctl_q.ref_sel  <= rc_sel;
                    ctl_q.ref_fsel <= rc_fsel;
                    ctl_q.mpll_mul <= rc_mul;
                    ctl_q.ssc_en   <= 1'b1;
                    ctl_q.ssp_en   <= 1'b1;
                    ctl_q.hs_pwr   <= 1'b1;
                    ctl_q.ss_pwr   <= 1'b1;
                    state_q        <= ST_WAIT_WRAP;
                end
                ST_WAIT_WRAP: begin
                    if (tmr_exp) begin
                        ctl_q.wrap_rst <= 1'b0;
                        state_q        <= ST_WAIT_PWR;
                    end
                end
                ST_WAIT_PWR: begin
                    if (tmr_exp) begin
                        ctl_q.ppc_en   <= cfg_q.pwr_present;
                        ctl_q.ppc_high <= cfg_q.pwr_present & ~cfg_q.pwr_low;
                        if (cfg_q.pwr_present) begin
                            state_q <= ST_SETTLE;
                        end else begin
                            ctl_q.core_rst <= 1'b0;
                            state_q        <= ST_WAIT_CORE;
                        end
                    end
                end
                ST_SETTLE: begin
                    if (tmr_exp) begin
                        ctl_q.core_rst <= 1'b0;
                        state_q        <= ST_WAIT_CORE;
                    end
                end
                ST_WAIT_CORE: begin
                    if (tmr_exp) begin
                        ctl_q.sclk_en <= 1'b1;
                        state_q       <= ST_HOST_MODE;
                    end
                end
                ST_HOST_MODE: begin
                    ctl_q.drd_mode <= 1'b0;
                    state_q        <= ST_PHY_REL;
                end
                ST_PHY_REL: begin
                    ctl_q.phy_rst <= 1'b0;
                    done_q        <= 1'b1;
                    state_q       <= ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign wrap_rst        = ctl_q.wrap_rst;
    assign core_rst        = ctl_q.core_rst;
    assign phy_rst         = ctl_q.phy_rst;
    assign hdiv_rst        = ctl_q.div_rst;
    assign hdiv_sel        = ctl_q.div_sel;
    assign hclk_en         = ctl_q.hclk_en;
    assign ref_sel         = ctl_q.ref_sel;
    assign ref_fsel        = ctl_q.ref_fsel;
    assign mpll_mul        = ctl_q.mpll_mul;
    assign ssc_en          = ctl_q.ssc_en;
    assign ssp_en          = ctl_q.ssp_en;
    assign hs_phy_pwr      = ctl_q.hs_pwr;
    assign ss_phy_pwr      = ctl_q.ss_pwr;
    assign ppc_en          = ctl_q.ppc_en;
    assign ppc_active_high = ctl_q.ppc_high;
    assign sclk_en         = ctl_q.sclk_en;
    assign drd_mode        = ctl_q.drd_mode;
    assign done            = done_q;
    assign error           = err_q;

endmodule

// File: rtl/usbpu_chk.sv
module usbpu_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic wrap_rst,
    input logic core_rst,
    input logic phy_rst,
    input logic hdiv_rst,
    input logic hclk_en,
    input logic ssc_en,
    input logic ssp_en,
    input logic hs_phy_pwr,
    input logic ss_phy_pwr,
    input logic ppc_en,
    input logic ppc_active_high,
    input logic sclk_en,
    input logic drd_mode,
    input logic done,
    input logic error
);
    // R2
    div_rst_under_reset_chk: assert property (@(posedge clk) disable iff (rst)
        hdiv_rst |-> (wrap_rst && core_rst && phy_rst));

    // R8
    ref_step_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ssp_en) |-> (ssc_en && hs_phy_pwr && ss_phy_pwr && !hdiv_rst && hclk_en));

    // R9
    core_after_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        !core_rst |-> !wrap_rst);

    // R11
    phy_last_chk: assert property (@(posedge clk) disable iff (rst)
        !phy_rst |-> (!core_rst && sclk_en && !drd_mode));

    // R10
    ppc_polarity_chk: assert property (@(posedge clk) disable iff (rst)
        ppc_active_high |-> ppc_en);

    // R12
    outcome_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, error}));

    // R12
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    // R12
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (error && !start) |=> error);

endmodule

bind usb_pwrup_seq usbpu_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .start           (start),
    .wrap_rst        (wrap_rst),
    .core_rst        (core_rst),
    .phy_rst         (phy_rst),
    .hdiv_rst        (hdiv_rst),
    .hclk_en         (hclk_en),
    .ssc_en          (ssc_en),
    .ssp_en          (ssp_en),
    .hs_phy_pwr      (hs_phy_pwr),
    .ss_phy_pwr      (ss_phy_pwr),
    .ppc_en          (ppc_en),
    .ppc_active_high (ppc_active_high),
    .sclk_en         (sclk_en),
    .drd_mode        (drd_mode),
    .done            (done),
    .error           (error)
);

// File: tb/usb_pwrup_seq_tb.sv
module usb_pwrup_seq_tb;

    typedef struct {
        int err;
        int lat;
        int divsel;
        int refsel;
        int fsel;
        int mul;
        int ppc;
        int ppc_hi;
        int n;
        int m;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  rate_code = '0;
    logic        hs_use_pll = 1'b0;
    logic        ss_src = 1'b0;
    logic [13:0] bus_mhz = '0;
    logic        port_pwr_present = 1'b0;
    logic        port_pwr_active_low = 1'b0;
    logic [15:0] wait_cycles = '0;
    logic [15:0] settle_cycles = '0;
    logic        corrupt = 1'b0;
    logic [2:0]  div_sel_rb;
    logic        hclk_en_rb;

    logic        wrap_rst, core_rst, phy_rst, hdiv_rst, hclk_en;
    logic [2:0]  hdiv_sel;
    logic [1:0]  ref_sel;
    logic [5:0]  ref_fsel;
    logic [6:0]  mpll_mul;
    logic        ssc_en, ssp_en, hs_phy_pwr, ss_phy_pwr;
    logic        ppc_en, ppc_active_high, sclk_en, drd_mode, done, error;

    int   cyc = 0;
    int   start_cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    exp_t sb_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign div_sel_rb = hdiv_sel ^ {2'b00, corrupt};
    assign hclk_en_rb = hclk_en;

    usb_pwrup_seq u_dut (
        .clk (clk), .rst (rst), .start (start),
        .rate_code (rate_code), .hs_use_pll (hs_use_pll), .ss_src (ss_src),
        .bus_mhz (bus_mhz), .port_pwr_present (port_pwr_present),
        .port_pwr_active_low (port_pwr_active_low),
        .wait_cycles (wait_cycles), .settle_cycles (settle_cycles),
        .div_sel_rb (div_sel_rb), .hclk_en_rb (hclk_en_rb),
        .wrap_rst (wrap_rst), .core_rst (core_rst), .phy_rst (phy_rst),
        .hdiv_rst (hdiv_rst), .hdiv_sel (hdiv_sel), .hclk_en (hclk_en),
        .ref_sel (ref_sel), .ref_fsel (ref_fsel), .mpll_mul (mpll_mul),
        .ssc_en (ssc_en), .ssp_en (ssp_en), .hs_phy_pwr (hs_phy_pwr),
        .ss_phy_pwr (ss_phy_pwr), .ppc_en (ppc_en),
        .ppc_active_high (ppc_active_high), .sclk_en (sclk_en),
        .drd_mode (drd_mode), .done (done), .error (error)
    );

    task automatic chk(input string req, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Monitor: event times and outcome comparison against the scoreboard.
    logic p_ssp = 1'b0, p_wrap = 1'b1, p_core = 1'b1, p_sclk = 1'b0;
    logic p_done = 1'b0, p_err = 1'b0;
    int   t_ssp = 0, t_wrap = 0, t_core = 0, t_sclk = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (ssp_en && !p_ssp)    t_ssp  = cyc;
            if (!wrap_rst && p_wrap) t_wrap = cyc;
            if (!core_rst && p_core) t_core = cyc;
            if (sclk_en && !p_sclk)  t_sclk = cyc;
            if ((done && !p_done) || (error && !p_err)) begin
                if (sb_q.size() == 0) begin
                    chk("R12 unexpected outcome", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk("R12 outcome is error", int'(error), e.err);
                    chk("R11 latency from start", cyc - start_cyc - 1, e.lat);
                    if (e.err != 0) begin
                        chk("R4 no ref setup after abort", int'(ssp_en), 0);
                        chk("R4 wrapper reset kept", int'(wrap_rst), 1);
                    end else begin
                        chk("R3 divider select", int'(hdiv_sel), e.divsel);
                        chk("R5 reference select", int'(ref_sel), e.refsel);
                        chk("R6 reference frequency", int'(ref_fsel), e.fsel);
                        chk("R7 pll multiplier", int'(mpll_mul), e.mul);
                        chk("R10 port power enable", int'(ppc_en), e.ppc);
                        chk("R10 port power polarity", int'(ppc_active_high), e.ppc_hi);
                        chk("R9 wrapper release wait", t_wrap - t_ssp, e.n);
                        chk("R9 core release wait", t_core - t_wrap, e.n + e.m);
                        chk("R11 coprocessor clock wait", t_sclk - t_core, e.n);
                        chk("R11 final reset state", {phy_rst, core_rst, wrap_rst, drd_mode}, 0);
                    end
                end
            end
        end
        p_ssp  = ssp_en;
        p_wrap = wrap_rst;
        p_core = core_rst;
        p_sclk = sclk_en;
        p_done = done;
        p_err  = error;
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 150000) begin
            chk("watchdog expired", 1, 0);
            finish_run();
        end
    end

    // Driver: push expectation, pulse start, wait for the scoreboard to drain.
    task automatic run_seq(input int bus, input int rate, input int hs, input int ss,
                           input int pres, input int low, input int w, input int s,
                           input int bad_rb, input int busy_poke, input exp_t e);
        @(negedge clk);
        bus_mhz             = 14'(bus);
        rate_code           = 2'(rate);
        hs_use_pll          = 1'(hs);
        ss_src              = 1'(ss);
        port_pwr_present    = 1'(pres);
        port_pwr_active_low = 1'(low);
        wait_cycles         = 16'(w);
        settle_cycles       = 16'(s);
        corrupt             = 1'(bad_rb);
        sb_q.push_back(e);
        start_cyc = cyc;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (busy_poke != 0) begin
            repeat (15) @(negedge clk);
            bus_mhz = 14'd100;
            start   = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (sb_q.size() != 0) @(negedge clk);
        corrupt = 1'b0;
    endtask

    function automatic exp_t mk(int err, int lat, int divsel, int refsel, int fsel,
                                int mul, int ppc, int ppc_hi, int n, int m);
        exp_t e;
        e.err = err; e.lat = lat; e.divsel = divsel; e.refsel = refsel;
        e.fsel = fsel; e.mul = mul; e.ppc = ppc; e.ppc_hi = ppc_hi;
        e.n = n; e.m = m;
        return e;
    endfunction

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 resets held", {wrap_rst, core_rst, phy_rst}, 7);
        chk("R1 dual-role default", int'(drd_mode), 1);
        chk("R1 other controls clear",
            {hdiv_rst, hclk_en, ssc_en, ssp_en, hs_phy_pwr, ss_phy_pwr, ppc_en, sclk_en}, 0);
        chk("R1 no outcome", {done, error}, 0);

        // R3 ratio 4, R6 0x27 at 100 MHz with source 0, wait below minimum
        run_seq(800, 0, 0, 0, 0, 0, 3, 0, 0, 0,
                mk(0, 36, 2, 0, 'h27, 'h19, 0, 0, 10, 0));
        // R2 resets re-asserted and divider reset set on a restart
        @(negedge clk);
        start_cyc = cyc; start = 1'b1; sb_q.push_back(mk(0, 36, 2, 0, 'h27, 'h19, 0, 0, 10, 0));
        @(negedge clk); start = 1'b0;
        chk("R2 resets asserted at edge 0", {wrap_rst, core_rst, phy_rst, hdiv_rst}, 'he);
        @(negedge clk);
        chk("R2 divider reset at edge 1", int'(hdiv_rst), 1);
        while (sb_q.size() != 0) @(negedge clk);

        // R7 50 MHz, R5 sel 3, R10 active-low power with settle wait
        run_seq(1200, 1, 1, 1, 1, 1, 12, 40, 0, 0,
                mk(0, 82, 4, 3, 'h07, 'h32, 1, 0, 12, 40));
        // R7 125 MHz, R5 sel 1, R3 largest ratio, R10 active-high, settle below minimum
        run_seq(9600, 2, 0, 1, 1, 0, 10, 5, 0, 0,
                mk(0, 46, 7, 1, 'h07, 'h28, 1, 1, 10, 10));
        // R7 unsupported rate, R6 sel 2 keeps 0x07, R3 ratio 1, R12 start while busy
        run_seq(200, 3, 1, 0, 0, 1, 20, 99, 0, 1,
                mk(0, 66, 0, 2, 'h07, 'h19, 0, 0, 20, 0));
        // R3 no ratio fits
        run_seq(100, 0, 0, 0, 0, 0, 10, 10, 0, 0,
                mk(1, 2, 0, 0, 0, 0, 0, 0, 0, 0));
        // R4 readback mismatch
        run_seq(800, 0, 0, 0, 0, 0, 10, 10, 1, 0,
                mk(1, 3, 0, 0, 0, 0, 0, 0, 0, 0));
        // R12 error holds
        repeat (20) @(negedge clk);
        chk("R12 error held", {error, done}, 2);
        chk("R4 divider reset still set", int'(hdiv_rst), 1);
        // R6 0x27 with source 1, R3 ratio 2, recovery from error
        run_seq(400, 0, 0, 1, 0, 0, 0, 0, 0, 0,
                mk(0, 36, 1, 1, 'h27, 'h19, 0, 0, 10, 0));
        repeat (10) @(negedge clk);
        chk("R12 done held", {done, error}, 2);

        finish_run();
    end

endmodule